// File: doc/BRIEF.md
# Keyed Window Watchdog

This block is a windowed watchdog timer that sits on a simple single-cycle register bus. Software first sets a 12-bit period and, optionally, a window size and a reaction type. It then arms the timer by writing a 32-bit enable word to the control register. While the timer runs, a down-counter falls by one every clock. Software keeps the timer alive by writing two fixed key words to the key register, in a fixed order. The completed pair reloads the counter, but only if the counter is inside the open window. Any other key word, a pair that completes while the window is closed, or a counter that reaches zero is a violation.

A violation sets a sticky timeout flag in the status register and raises the selected reaction. The reaction is either a one-cycle reset request or a non-maskable interrupt request that stays high until software clears the flag. Once the timer is armed, its setup is frozen until the next system reset. The live counter can be read at any time.

Top module: `keyed_window_wdog`

## Requirements
- R1: After reset the counter reads 0, control reads 0, status reads 0, preload reads 0xFFF, window-size and reaction codes read 0x5, and both reaction outputs are low.
- R2: The timer starts only when 0xA98559DA is written to offset 0x90. Any other value leaves it stopped with the counter at 0. While running, offset 0x90 reads back 0xA98559DA.
- R3: On start, the counter at offset 0xA0 loads the preload (offset 0x94, 12 bits) shifted left by SHIFT bit positions. It then decreases by one every clock. A read returns the value the counter held before the sampling edge.
- R4: While running, writes to the preload, window-size (0xA8), reaction (0xA4) and control registers have no effect until system reset.
- R5: Writing 0xE51A and then 0xA35C to the key register at 0x9C, with the window open, reloads the counter to the start value.
- R6: While running, a key word that is not the expected next word (0xE51A when idle, 0xA35C after 0xE51A) is a violation. Key writes while stopped are ignored.
- R7: With window code 0x50, a completed pair is accepted only while the counter is at or below half the start value. Otherwise it is a violation and does not reload the counter. Any other code, including 0x5, keeps the window open for the whole period.
- R8: A counter that reaches zero is a violation. The counter then holds at zero until reset, and key writes are ignored.
- R9: A violation sets bit 1 of the status register (0x98) at the edge that sees it. Writing a 1 to bit 1 clears the flag, and a new violation takes priority over a clear in the same cycle.
- R10: With reaction code 0xA, a violation raises nmi_req, which stays high until the status flag is cleared. With any other code, it raises rst_req for exactly one cycle. Both outputs change at the edge that sees the violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst | input | 1 | Synchronous active-high system reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after bus_rd |
| rst_req | output | 1 | One-cycle reset request on violation |
| nmi_req | output | 1 | Level interrupt request on violation, cleared with the status flag |

## Verification
Every write takes effect at the clock edge that samples it. The status flag, the reaction outputs and a counter reload all change at that same edge. Read data appears one edge after the read strobe and carries the register value from before that edge, so a counter read that directly follows an arming or service write returns exactly the start value. The bench drives and samples on falling edges, and it derives each expected counter value by counting the rising edges between the last reload and the sampling edge. It counts reset-request pulses with a falling-edge monitor and reads that tally only after one extra falling edge, so the monitor and the checking task never race.

// File: rtl/kww_pkg.sv
package kww_pkg;
  localparam logic [7:0]  OFS_CTRL    = 8'h90;
  localparam logic [7:0]  OFS_PRELOAD = 8'h94;
  localparam logic [7:0]  OFS_STATUS  = 8'h98;
  localparam logic [7:0]  OFS_KEY     = 8'h9C;
  localparam logic [7:0]  OFS_COUNT   = 8'hA0;
  localparam logic [7:0]  OFS_REACT   = 8'hA4;
  localparam logic [7:0]  OFS_WINDOW  = 8'hA8;

  localparam logic [31:0] ARM_WORD    = 32'hA98559DA;
  localparam logic [31:0] KEY_FIRST   = 32'h0000E51A;
  localparam logic [31:0] KEY_SECOND  = 32'h0000A35C;

  localparam logic [7:0]  WIN_FULL    = 8'h05;
  localparam logic [7:0]  WIN_HALF    = 8'h50;
  localparam logic [7:0]  REACT_NMI   = 8'h0A;
  localparam logic [7:0]  REACT_RESET = 8'h05;

  localparam int          FLAG_BIT    = 1;
endpackage

// File: rtl/kww_regs.sv
module kww_regs
  import kww_pkg::*;
#(
  parameter int PRELOAD_W = 12,
  parameter int CNT_W     = 25
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [7:0]           bus_addr,
  input  logic [31:0]          bus_wdata,
  input  logic [CNT_W-1:0]     cnt,
  input  logic                 status_flag,
  output logic                 running,
  output logic                 start_pulse,
  output logic [PRELOAD_W-1:0] preload_q,
  output logic                 win_half,
  output logic                 nmi_sel,
  output logic                 key_wr,
  output logic                 sts_clr,
  output logic [31:0]          bus_rdata
);
  logic [7:0]  win_code;
  logic [7:0]  react_code;
  logic        cfg_wr;
  logic [31:0] rd_mux;

  assign cfg_wr      = bus_wr && !running;
  assign start_pulse = cfg_wr && (bus_addr == OFS_CTRL) && (bus_wdata == ARM_WORD);
  assign key_wr      = bus_wr && running && (bus_addr == OFS_KEY);
  assign sts_clr     = bus_wr && (bus_addr == OFS_STATUS) && bus_wdata[FLAG_BIT];
  assign win_half    = (win_code == WIN_HALF);
  assign nmi_sel     = (react_code == REACT_NMI);

  always_ff @(posedge clk) begin
    if (rst) begin
      running    <= 1'b0;
      preload_q  <= '1;
      win_code   <= WIN_FULL;
      react_code <= REACT_RESET;
    end else begin
      if (start_pulse)
        running <= 1'b1;
      if (cfg_wr && bus_addr == OFS_PRELOAD)
        preload_q <= bus_wdata[PRELOAD_W-1:0];
      if (cfg_wr && bus_addr == OFS_WINDOW)
        win_code <= bus_wdata[7:0];
      if (cfg_wr && bus_addr == OFS_REACT)
        react_code <= bus_wdata[7:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (bus_addr)
      OFS_CTRL:    rd_mux = running ? ARM_WORD : 32'h0;
      OFS_PRELOAD: rd_mux = {{(32-PRELOAD_W){1'b0}}, preload_q};
      OFS_STATUS:  rd_mux[FLAG_BIT] = status_flag;
      OFS_COUNT:   rd_mux = {{(32-CNT_W){1'b0}}, cnt};
      OFS_REACT:   rd_mux = {24'h0, react_code};
      OFS_WINDOW:  rd_mux = {24'h0, win_code};
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else if (bus_rd)
      bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/kww_counter.sv
module kww_counter #(
  parameter int PRELOAD_W = 12,
  parameter int SHIFT     = 13,
  localparam int CNT_W    = PRELOAD_W + SHIFT
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 running,
  input  logic                 start_pulse,
  input  logic                 svc_ok,
  input  logic [PRELOAD_W-1:0] preload_q,
  input  logic                 win_half,
  output logic [CNT_W-1:0]     cnt,
  output logic                 win_open,
  output logic                 expired,
  output logic                 expire_evt
);
  logic [CNT_W-1:0] start_val;
  logic [CNT_W-1:0] half_val;
  logic             load;

  assign start_val  = {preload_q, {SHIFT{1'b0}}};
  assign half_val   = start_val >> 1;
  assign load       = start_pulse || svc_ok;
  assign win_open   = !win_half || (cnt <= half_val);
  assign expired    = running && (cnt == '0);
  assign expire_evt = running && !load && (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= start_val;
    else if (running && cnt != '0)
      cnt <= cnt - CNT_W'(1);
  end
endmodule

// File: rtl/kww_keyseq.sv
module kww_keyseq
  import kww_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        key_wr,
  input  logic [31:0] key_data,
  input  logic        expired,
  input  logic        win_open,
  output logic        svc_ok,
  output logic        key_viol
);
  logic armed;
  logic active;
  logic first_ok;
  logic second_hit;

  assign active     = key_wr && !expired;
  assign first_ok   = !armed && (key_data == KEY_FIRST);
  assign second_hit = armed && (key_data == KEY_SECOND);
  assign svc_ok     = active && second_hit && win_open;
  assign key_viol   = active && !first_ok && !svc_ok;

  always_ff @(posedge clk) begin
    if (rst)
      armed <= 1'b0;
    else if (active)
      armed <= first_ok;
  end
endmodule

// File: rtl/kww_react.sv
module kww_react (
  input  logic clk,
  input  logic rst,
  input  logic viol,
  input  logic nmi_sel,
  input  logic sts_clr,
  output logic status_flag,
  output logic rst_req,
  output logic nmi_req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      status_flag <= 1'b0;
      rst_req     <= 1'b0;
      nmi_req     <= 1'b0;
    end else begin
      rst_req <= viol && !nmi_sel;
      if (viol)
        status_flag <= 1'b1;
      else if (sts_clr)
        status_flag <= 1'b0;
      if (viol && nmi_sel)
        nmi_req <= 1'b1;
      else if (sts_clr)
        nmi_req <= 1'b0;
    end
  end
endmodule

// File: rtl/keyed_window_wdog.sv
module keyed_window_wdog #(
  parameter int PRELOAD_W = 12,
  parameter int SHIFT     = 13,
  localparam int CNT_W    = PRELOAD_W + SHIFT
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        rst_req,
  output logic        nmi_req
);
  logic                 running;
  logic                 start_pulse;
  logic [PRELOAD_W-1:0] preload_q;
  logic                 win_half;
  logic                 nmi_sel;
  logic                 key_wr;
  logic                 sts_clr;
  logic [CNT_W-1:0]     cnt;
  logic                 win_open;
  logic                 expired;
  logic                 expire_evt;
  logic                 svc_ok;
  logic                 key_viol;
  logic                 status_flag;
  logic                 viol;

  assign viol = key_viol || expire_evt;

  kww_regs #(.PRELOAD_W(PRELOAD_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt(cnt),
    .status_flag(status_flag), .running(running), .start_pulse(start_pulse),
    .preload_q(preload_q), .win_half(win_half), .nmi_sel(nmi_sel),
    .key_wr(key_wr), .sts_clr(sts_clr), .bus_rdata(bus_rdata)
  );

  kww_counter #(.PRELOAD_W(PRELOAD_W), .SHIFT(SHIFT)) u_cnt (
    .clk(clk), .rst(rst), .running(running), .start_pulse(start_pulse),
    .svc_ok(svc_ok), .preload_q(preload_q), .win_half(win_half),
    .cnt(cnt), .win_open(win_open), .expired(expired), .expire_evt(expire_evt)
  );

  kww_keyseq u_key (
    .clk(clk), .rst(rst), .key_wr(key_wr), .key_data(bus_wdata),
    .expired(expired), .win_open(win_open), .svc_ok(svc_ok), .key_viol(key_viol)
  );

  kww_react u_react (
    .clk(clk), .rst(rst), .viol(viol), .nmi_sel(nmi_sel), .sts_clr(sts_clr),
    .status_flag(status_flag), .rst_req(rst_req), .nmi_req(nmi_req)
  );
endmodule

// File: rtl/kww_checker.sv
module kww_checker #(
  parameter int PRELOAD_W = 12,
  parameter int CNT_W     = 25
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 running,
  input logic [CNT_W-1:0]     cnt,
  input logic                 svc_ok,
  input logic                 sts_clr,
  input logic                 status_flag,
  input logic [PRELOAD_W-1:0] preload_q,
  input logic                 rst_req,
  input logic                 nmi_req
);
  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req); // R10
  AST_NMI_STICKY: assert property (@(posedge clk) disable iff (rst)
    (nmi_req && !sts_clr) |=> nmi_req); // R10
  AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (rst)
    (running && cnt == '0) |=> (cnt == '0)); // R8
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    running |=> (running && $stable(preload_q))); // R4
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (running && cnt != '0 && !svc_ok) |=> (cnt == $past(cnt) - CNT_W'(1))); // R3
  AST_FLAG_WITH_REACT: assert property (@(posedge clk) disable iff (rst)
    (rst_req || nmi_req) |-> status_flag); // R9
endmodule

bind keyed_window_wdog kww_checker #(.PRELOAD_W(PRELOAD_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .running(running), .cnt(cnt), .svc_ok(svc_ok),
  .sts_clr(sts_clr), .status_flag(status_flag), .preload_q(preload_q),
  .rst_req(rst_req), .nmi_req(nmi_req)
);

// File: tb/sim_keyed_window_wdog.sv
`timescale 1ns/1ps
module sim_keyed_window_wdog;
  localparam int SHIFT = 4;
  localparam logic [31:0] ARM = 32'hA98559DA;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rst_req;
  logic        nmi_req;

  int total = 0;
  int bad = 0;
  int rst_cnt = 0;

  always #4 clk = ~clk;

  keyed_window_wdog #(.PRELOAD_W(12), .SHIFT(SHIFT)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rst_req(rst_req), .nmi_req(nmi_req)
  );

  always @(negedge clk) if (rst_req) rst_cnt++;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    rst_cnt = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    rd(8'hA0, v); check("R1 counter", v, 0);
    rd(8'h90, v); check("R1 control", v, 0);
    rd(8'h98, v); check("R1 status", v, 0);
    rd(8'h94, v); check("R1 preload", v, 32'hFFF);
    rd(8'hA8, v); check("R1 window", v, 32'h5);
    rd(8'hA4, v); check("R1 reaction", v, 32'h5);
    check("R1 outputs", {30'h0, rst_req, nmi_req}, 0);
  endtask

  task automatic t_enable_count();
    logic [31:0] v;
    do_reset();
    wr(8'h94, 32'h10);
    wr(8'h90, 32'h12345678);
    rd(8'h90, v); check("R2 wrong word control", v, 0);
    rd(8'hA0, v); check("R2 wrong word counter", v, 0);
    wr(8'h90, ARM);
    rd(8'hA0, v); check("R3 start value", v, 32'h100);
    repeat (20) @(negedge clk);
    rd(8'hA0, v); check("R3 countdown", v, 32'h100 - 21);
    rd(8'h90, v); check("R2 control reads arm word", v, ARM);
  endtask

  task automatic t_lock();
    logic [31:0] v;
    do_reset();
    wr(8'h94, 32'h20);
    wr(8'h90, ARM);
    wr(8'h94, 32'h7);
    wr(8'hA8, 32'h50);
    wr(8'hA4, 32'hA);
    wr(8'h90, 32'h0);
    rd(8'h94, v); check("R4 preload locked", v, 32'h20);
    rd(8'hA8, v); check("R4 window locked", v, 32'h5);
    rd(8'hA4, v); check("R4 reaction locked", v, 32'h5);
    rd(8'h90, v); check("R4 control locked", v, ARM);
  endtask

  task automatic t_service();
    logic [31:0] v;
    do_reset();
    wr(8'h9C, 32'h1234);
    repeat (2) @(negedge clk);
    check("R6 key ignored when stopped rst", rst_cnt, 0);
    rd(8'h98, v); check("R6 key ignored when stopped status", v, 0);
    wr(8'h94, 32'h10);
    wr(8'h90, ARM);
    repeat (50) @(negedge clk);
    wr(8'h9C, 32'hE51A);
    wr(8'h9C, 32'hA35C);
    rd(8'hA0, v); check("R5 reload full window (R7)", v, 32'h100);
    repeat (2) @(negedge clk);
    check("R5 no violation", rst_cnt, 0);
  endtask

  task automatic t_badkey();
    logic [31:0] v;
    do_reset();
    wr(8'h90, ARM);
    wr(8'h9C, 32'h1234);
    check("R10 rst_req pulse high", rst_req, 1);
    @(negedge clk);
    check("R10 rst_req pulse low", rst_req, 0);
    @(negedge clk);
    check("R10 one pulse", rst_cnt, 1);
    rd(8'h98, v); check("R9 flag set", v, 32'h2);
    wr(8'h98, 32'h2);
    rd(8'h98, v); check("R9 flag cleared", v, 0);
    wr(8'h9C, 32'hA35C);
    repeat (2) @(negedge clk);
    check("R6 second word first", rst_cnt, 2);
    wr(8'h9C, 32'hE51A);
    wr(8'h9C, 32'hE51A);
    repeat (2) @(negedge clk);
    check("R6 repeated first word", rst_cnt, 3);
  endtask

  task automatic t_window();
    logic [31:0] v;
    do_reset();
    wr(8'h94, 32'h10);
    wr(8'hA8, 32'h50);
    wr(8'hA4, 32'hA);
    wr(8'h90, ARM);
    wr(8'h9C, 32'hE51A);
    wr(8'h9C, 32'hA35C);
    check("R7 early service nmi", nmi_req, 1);
    rd(8'h98, v); check("R7 early service flag", v, 32'h2);
    repeat (5) @(negedge clk);
    check("R10 nmi held", nmi_req, 1);
    check("R10 no reset pulse in nmi mode", rst_cnt, 0);
    wr(8'h98, 32'h2);
    check("R10 nmi cleared with flag", nmi_req, 0);
    repeat (140) @(negedge clk);
    wr(8'h9C, 32'hE51A);
    wr(8'h9C, 32'hA35C);
    rd(8'hA0, v); check("R7 late service reload", v, 32'h100);
    check("R7 late service no nmi", nmi_req, 0);
    rd(8'h98, v); check("R7 late service flag clear", v, 0);
  endtask

  task automatic t_expire();
    logic [31:0] v;
    do_reset();
    wr(8'h94, 32'h2);
    wr(8'h90, ARM);
    repeat (40) @(negedge clk);
    rd(8'hA0, v); check("R8 counter zero", v, 0);
    rd(8'h98, v); check("R8 expiry flag", v, 32'h2);
    check("R8 expiry reset pulse", rst_cnt, 1);
    wr(8'h9C, 32'hE51A);
    wr(8'h9C, 32'hA35C);
    rd(8'hA0, v); check("R8 holds zero after keys", v, 0);
    @(negedge clk);
    check("R8 keys ignored after expiry", rst_cnt, 1);
  endtask

  initial begin
    #(8.0 * 200000);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_enable_count();
    t_lock();
    t_service();
    t_badkey();
    t_window();
    t_expire();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule